// File: doc/BRIEF.md
# Per-CPU Masked Device Interrupt Router

This block collects level interrupt requests from up to 64 device sources into one shared request vector. It routes them to a small set of CPUs, each of which has its own 64-bit enable mask. For every CPU the set of pending sources is the bitwise AND of the shared request vector and that CPU's mask. The CPU's interrupt line is high whenever that set is non-empty.

Devices drive single-cycle raise and clear strobes, each carrying a source index. Software reaches the masks, the pending sets and the request vector through a simple 64-bit register port. Every change is also reported as one-cycle event vectors, one post vector and one clear vector per CPU. A post marks a source that has just been delivered to a CPU. A clear marks a source that has stopped being delivered to it. A mask update produces events only for the mask bits that actually change.

Top module: `irq_mask_router`

## Requirements
- R1: After reset the request vector and every mask are zero, every `cpu_irq` bit is low, both event vectors are zero, and `reg_rdata` and `reg_err` are zero.
- R2: A raise strobe for source n sets request bit n at the next clock edge. In the same cycle, `evt_post` bit c*64+n pulses for every CPU c whose mask (after any mask write in that cycle) has bit n set. This happens even if the source was already requested.
- R3: A clear strobe for source n whose request bit is set clears that bit. `evt_clr` bit c*64+n pulses for every CPU c that had source n pending.
- R4: A clear strobe for a source whose request bit is already zero is spurious: it changes no state and produces no event.
- R5: A raise and a clear for the same source in the same cycle leave the request bit set. Each CPU whose mask enables the source gets a post, and no clear is produced.
- R6: A mask write posts the sources that become enabled and are requested. It clears the sources that were pending before the write and are not pending after it. Mask bits that do not change produce no event.
- R7: `cpu_irq[c]` is high exactly while CPU c's pending set (mask AND request) is non-zero.
- R8: When address bits 15 and 14 are zero, the register index is `reg_addr[13:6]`. Index c (c below the CPU count N) is CPU c's mask, read/write. Index N+c is CPU c's pending set, read-only. Index 2N is the request vector, read-only. Read data appears on `reg_rdata` one cycle after the access.
- R9: With `reg_addr[15]` set, `reg_addr[9:4]` selects a CPU whose mask is read or written. With bit 15 clear and bit 14 set, the same field selects a CPU whose pending set is read. Bit 15 takes precedence over bit 14.
- R10: An access is refused if any of the following holds: `reg_size` is not 3 (64-bit); `reg_addr[3:0]` is non-zero; the index is undecoded; a read-only register is written; the CPU field is not below N. A refused access pulses `reg_err` one cycle later, returns zero data and changes no mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_raise_vld | input | 1 | Raise strobe from a device |
| src_raise_idx | input | 6 | Source index of the raise |
| src_clr_vld | input | 1 | Clear strobe from a device |
| src_clr_idx | input | 6 | Source index of the clear |
| reg_vld | input | 1 | Register access valid |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 16 | Byte offset of the access |
| reg_size | input | 2 | Log2 of the access size in bytes; 3 is the only legal value |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, one cycle after the access |
| reg_err | output | 1 | Access refused, one cycle after the access |
| cpu_irq | output | 4 | Per-CPU interrupt level |
| evt_post | output | 256 | One-cycle post events, bit c*64+n for CPU c and source n |
| evt_clr | output | 256 | One-cycle clear events, same layout |

## Verification
All results are due one clock after the edge that captures the stimulus:
- the request vector, the masks, both event vectors and `cpu_irq` change at that edge;
- a register read returns the state from before that edge, also one cycle later.

The bench applies each stimulus on the falling edge and samples every output shortly after the next rising edge. Its model of the request vector and masks advances only at that point, so each expected value is tied to exactly one capturing edge. Sweeps over every source index, with differing mask patterns per CPU, cover both the single-CPU and the multi-CPU delivery cases.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam logic [1:0] SZ_DWORD    = 2'd3;
  localparam int         CPU_FIELD_W = 6;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_MASK = 2'd1,
    TGT_PEND = 2'd2,
    TGT_REQ  = 2'd3
  } tgt_e;

  typedef struct packed {
    tgt_e                   tgt;
    logic [CPU_FIELD_W-1:0] cpu;
    logic                   err;
  } acc_dec_t;
endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_route_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int NUM_CPU = 4
) (
  input  logic              acc_vld,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_size,
  output acc_dec_t          dec
);
  localparam int ALT_MASK_BIT = ADDR_W - 1;
  localparam int ALT_PEND_BIT = ADDR_W - 2;
  localparam int IDX_LO       = 6;
  localparam int IDX_W        = ALT_PEND_BIT - IDX_LO;
  localparam logic [IDX_W-1:0]     IDX_PEND = IDX_W'(NUM_CPU);
  localparam logic [IDX_W-1:0]     IDX_REQ  = IDX_W'(2 * NUM_CPU);
  localparam logic [CPU_FIELD_W:0] CPU_LIM  = (CPU_FIELD_W + 1)'(NUM_CPU);

  logic [IDX_W-1:0]       idx;
  logic [IDX_W-1:0]       pend_off;
  logic [CPU_FIELD_W-1:0] alt_cpu;
  logic                   alt_cpu_ok;
  logic                   aligned;

  assign idx        = acc_addr[ALT_PEND_BIT-1:IDX_LO];
  assign pend_off   = idx - IDX_PEND;
  assign alt_cpu    = acc_addr[IDX_LO+3:4];
  assign alt_cpu_ok = ({1'b0, alt_cpu} < CPU_LIM);
  assign aligned    = (acc_addr[3:0] == 4'd0);

  always_comb begin
    dec = '{tgt: TGT_NONE, cpu: '0, err: 1'b0};
    if (acc_vld) begin
      if ((acc_size != SZ_DWORD) || !aligned) begin
        dec.err = 1'b1;
      end else if (acc_addr[ALT_MASK_BIT]) begin
        if (alt_cpu_ok) begin
          dec.tgt = TGT_MASK;
          dec.cpu = alt_cpu;
        end else begin
          dec.err = 1'b1;
        end
      end else if (acc_addr[ALT_PEND_BIT]) begin
        if (alt_cpu_ok && !acc_wr) begin
          dec.tgt = TGT_PEND;
          dec.cpu = alt_cpu;
        end else begin
          dec.err = 1'b1;
        end
      end else if (idx < IDX_PEND) begin
        dec.tgt = TGT_MASK;
        dec.cpu = CPU_FIELD_W'(idx);
      end else if (idx < IDX_REQ) begin
        if (acc_wr) begin
          dec.err = 1'b1;
        end else begin
          dec.tgt = TGT_PEND;
          dec.cpu = CPU_FIELD_W'(pend_off);
        end
      end else if (idx == IDX_REQ) begin
        if (acc_wr) dec.err = 1'b1;
        else        dec.tgt = TGT_REQ;
      end else begin
        dec.err = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_req_vec.sv
module irq_req_vec #(
  parameter int NUM_SRC = 64,
  localparam int SRC_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               raise_vld,
  input  logic [SRC_W-1:0]   raise_idx,
  input  logic               clr_vld,
  input  logic [SRC_W-1:0]   clr_idx,
  output logic [NUM_SRC-1:0] req_o,
  output logic [NUM_SRC-1:0] req_next_o,
  output logic [NUM_SRC-1:0] raise_oh_o
);
  logic [NUM_SRC-1:0] req_q;
  logic [NUM_SRC-1:0] clr_oh;
  logic               req_en;

  always_comb begin
    raise_oh_o = '0;
    clr_oh     = '0;
    if (raise_vld) raise_oh_o[raise_idx] = 1'b1;
    if (clr_vld)   clr_oh[clr_idx]       = 1'b1;
    clr_oh     = clr_oh & req_q;
    req_next_o = (req_q & ~clr_oh) | raise_oh_o;
    req_en     = raise_vld | clr_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      req_q <= '0;
    else if (req_en) req_q <= req_next_o;
  end

  assign req_o = req_q;

  p_raise_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    raise_vld |=> req_q[$past(raise_idx)]);

  p_clear_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vld && !(raise_vld && raise_idx == clr_idx)) |=> !req_q[$past(clr_idx)]);

  p_spurious_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vld && !raise_vld && !req_q[clr_idx]) |=> (req_q == $past(req_q)));
endmodule

// File: rtl/irq_cpu_lane.sv
module irq_cpu_lane #(
  parameter int NUM_SRC = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [NUM_SRC-1:0] wr_data,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [NUM_SRC-1:0] req_next_i,
  input  logic [NUM_SRC-1:0] raise_oh_i,
  output logic [NUM_SRC-1:0] mask_o,
  output logic [NUM_SRC-1:0] pend_o,
  output logic               irq_o,
  output logic [NUM_SRC-1:0] post_o,
  output logic [NUM_SRC-1:0] clr_o
);
  logic [NUM_SRC-1:0] mask_q, mask_d;
  logic [NUM_SRC-1:0] pend_d;
  logic [NUM_SRC-1:0] post_q, post_d;
  logic [NUM_SRC-1:0] clr_q, clr_d;

  always_comb begin
    mask_d = wr_en ? wr_data : mask_q;
    pend_o = mask_q & req_i;
    pend_d = mask_d & req_next_i;
    post_d = pend_d & (raise_oh_i | (mask_d & ~mask_q));
    clr_d  = pend_o & ~pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (wr_en) begin
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      post_q <= '0;
      clr_q  <= '0;
    end else begin
      post_q <= post_d;
      clr_q  <= clr_d;
    end
  end

  assign mask_o = mask_q;
  assign irq_o  = |pend_o;
  assign post_o = post_q;
  assign clr_o  = clr_q;

  p_irq_rise_posted_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> (|post_q));

  p_irq_fall_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) |-> (|clr_q));

  p_same_mask_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !(|raise_oh_i) && (req_next_i == req_i) && (wr_data == mask_q))
    |=> (!(|post_q) && !(|clr_q)));
endmodule

// File: rtl/irq_mask_router.sv
module irq_mask_router
  import irq_route_pkg::*;
#(
  parameter int  NUM_CPU = 4,
  parameter int  NUM_SRC = 64,
  parameter int  ADDR_W  = 16,
  localparam int SRC_W   = $clog2(NUM_SRC),
  localparam int EVT_W   = NUM_CPU * NUM_SRC
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               src_raise_vld,
  input  logic [SRC_W-1:0]   src_raise_idx,
  input  logic               src_clr_vld,
  input  logic [SRC_W-1:0]   src_clr_idx,
  input  logic               reg_vld,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [1:0]         reg_size,
  input  logic [NUM_SRC-1:0] reg_wdata,
  output logic [NUM_SRC-1:0] reg_rdata,
  output logic               reg_err,
  output logic [NUM_CPU-1:0] cpu_irq,
  output logic [EVT_W-1:0]   evt_post,
  output logic [EVT_W-1:0]   evt_clr
);
  localparam int CIDX_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;

  logic [1:0]         rst_pipe;
  logic               rst_n_s;
  acc_dec_t           dec;
  logic [CIDX_W-1:0]  cidx;
  logic [NUM_SRC-1:0] req_q, req_next, raise_oh;
  logic [EVT_W-1:0]   mask_flat, pend_flat;
  logic [NUM_SRC-1:0] rd_d, rdata_q;
  logic               err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  irq_reg_decode #(.ADDR_W(ADDR_W), .NUM_CPU(NUM_CPU)) u_dec (
    .acc_vld  (reg_vld),
    .acc_wr   (reg_wr),
    .acc_addr (reg_addr),
    .acc_size (reg_size),
    .dec      (dec)
  );

  irq_req_vec #(.NUM_SRC(NUM_SRC)) u_req (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .raise_vld  (src_raise_vld),
    .raise_idx  (src_raise_idx),
    .clr_vld    (src_clr_vld),
    .clr_idx    (src_clr_idx),
    .req_o      (req_q),
    .req_next_o (req_next),
    .raise_oh_o (raise_oh)
  );

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_lane
    logic lane_we;
    assign lane_we = reg_vld & reg_wr & ~dec.err & (dec.tgt == TGT_MASK) &
                     (dec.cpu == CPU_FIELD_W'(g));

    irq_cpu_lane #(.NUM_SRC(NUM_SRC)) u_lane (
      .clk        (clk),
      .rst_n      (rst_n_s),
      .wr_en      (lane_we),
      .wr_data    (reg_wdata),
      .req_i      (req_q),
      .req_next_i (req_next),
      .raise_oh_i (raise_oh),
      .mask_o     (mask_flat[g*NUM_SRC +: NUM_SRC]),
      .pend_o     (pend_flat[g*NUM_SRC +: NUM_SRC]),
      .irq_o      (cpu_irq[g]),
      .post_o     (evt_post[g*NUM_SRC +: NUM_SRC]),
      .clr_o      (evt_clr[g*NUM_SRC +: NUM_SRC])
    );
  end

  assign cidx = dec.cpu[CIDX_W-1:0];

  always_comb begin
    rd_d = '0;
    if (!reg_wr) begin
      case (dec.tgt)
        TGT_MASK: rd_d = mask_flat[cidx*NUM_SRC +: NUM_SRC];
        TGT_PEND: rd_d = pend_flat[cidx*NUM_SRC +: NUM_SRC];
        TGT_REQ:  rd_d = req_q;
        default:  rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      rdata_q <= rd_d;
      err_q   <= dec.err;
    end
  end

  assign reg_rdata = rdata_q;
  assign reg_err   = err_q;

  p_err_keeps_masks_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    reg_err |-> $stable(mask_flat));

  p_err_zero_data_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    reg_err |-> (reg_rdata == '0));
endmodule

// File: tb/tb_irq_mask_router.sv
`timescale 1ns/1ps
module tb_irq_mask_router;
  localparam int NC = 4;
  localparam int NS = 64;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         src_raise_vld, src_clr_vld;
  logic [5:0]   src_raise_idx, src_clr_idx;
  logic         reg_vld, reg_wr;
  logic [15:0]  reg_addr;
  logic [1:0]   reg_size;
  logic [63:0]  reg_wdata, reg_rdata;
  logic         reg_err;
  logic [NC-1:0] cpu_irq;
  logic [NC*NS-1:0] evt_post, evt_clr;

  always #2 clk = ~clk;

  irq_mask_router dut (
    .clk(clk), .rst_n(rst_n),
    .src_raise_vld(src_raise_vld), .src_raise_idx(src_raise_idx),
    .src_clr_vld(src_clr_vld), .src_clr_idx(src_clr_idx),
    .reg_vld(reg_vld), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_size(reg_size), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_err(reg_err), .cpu_irq(cpu_irq),
    .evt_post(evt_post), .evt_clr(evt_clr)
  );

  logic [63:0] m_req;
  logic [63:0] m_mask [NC];
  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  task automatic check(input bit ok, input string tag,
                       input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Decode per R8, R9, R10: kind 0 none, 1 mask, 2 pending, 3 request
  task automatic bdec(input bit av, input bit aw, input logic [15:0] ad,
                      input logic [1:0] sz, output int kind, output int cpu,
                      output bit err);
    int i;
    kind = 0; cpu = 0; err = 1'b0;
    i = int'(ad[13:6]);
    if (!av) return;
    if (sz != 2'd3 || ad[3:0] != 4'd0) err = 1'b1;
    else if (ad[15]) begin
      cpu = int'(ad[9:4]);
      if (cpu >= NC) err = 1'b1; else kind = 1;
    end else if (ad[14]) begin
      cpu = int'(ad[9:4]);
      if (cpu >= NC || aw) err = 1'b1; else kind = 2;
    end else if (i < NC) begin
      kind = 1; cpu = i;
    end else if (i < 2*NC) begin
      if (aw) err = 1'b1; else begin kind = 2; cpu = i - NC; end
    end else if (i == 2*NC) begin
      if (aw) err = 1'b1; else kind = 3;
    end else err = 1'b1;
  endtask

  task automatic step(input bit rv, input int ri, input bit cv, input int ci,
                      input bit av, input bit aw, input logic [15:0] ad,
                      input logic [1:0] sz, input logic [63:0] wd,
                      input string tag);
    logic [63:0]  rbit, cbit, nreq, exp_rd, op, np;
    logic [63:0]  nmask [NC];
    logic [255:0] ep, ec;
    logic [NC-1:0] eirq;
    int kind, cpu;
    bit err;
    bdec(av, aw, ad, sz, kind, cpu, err);
    rbit = rv ? (64'd1 << ri) : 64'd0;
    cbit = (cv && m_req[ci]) ? (64'd1 << ci) : 64'd0;
    nreq = (m_req & ~cbit) | rbit;
    for (int c = 0; c < NC; c++) nmask[c] = m_mask[c];
    if (aw && kind == 1) nmask[cpu] = wd;
    exp_rd = 64'd0;
    if (!aw) begin
      if (kind == 1) exp_rd = m_mask[cpu];
      if (kind == 2) exp_rd = m_mask[cpu] & m_req;
      if (kind == 3) exp_rd = m_req;
    end
    ep = '0; ec = '0; eirq = '0;
    for (int c = 0; c < NC; c++) begin
      op = m_mask[c] & m_req;
      np = nmask[c] & nreq;
      ep[c*NS +: NS] = np & (rbit | (nmask[c] & ~m_mask[c]));
      ec[c*NS +: NS] = op & ~np;
      eirq[c] = |np;
    end
    @(negedge clk);
    src_raise_vld = rv; src_raise_idx = 6'(ri);
    src_clr_vld = cv;   src_clr_idx = 6'(ci);
    reg_vld = av; reg_wr = aw; reg_addr = ad; reg_size = sz; reg_wdata = wd;
    @(posedge clk); #1;
    check(evt_post == ep, {tag, " post"}, 256'(evt_post), ep);
    check(evt_clr == ec, {tag, " clear"}, 256'(evt_clr), ec);
    check(cpu_irq == eirq, {tag, " R7 irq"}, 256'(cpu_irq), 256'(eirq));
    check(reg_rdata == exp_rd, {tag, " rdata"}, 256'(reg_rdata), 256'(exp_rd));
    check(reg_err == err, {tag, " err"}, 256'(reg_err), 256'(err));
    m_req = nreq;
    for (int c = 0; c < NC; c++) m_mask[c] = nmask[c];
    src_raise_vld = 1'b0; src_clr_vld = 1'b0; reg_vld = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic raise_s(input int s, input string tag);
    step(1, s, 0, 0, 0, 0, 16'h0, 2'd3, 64'h0, tag);
  endtask
  task automatic clear_s(input int s, input string tag);
    step(0, 0, 1, s, 0, 0, 16'h0, 2'd3, 64'h0, tag);
  endtask
  task automatic rd(input logic [15:0] ad, input string tag);
    step(0, 0, 0, 0, 1, 0, ad, 2'd3, 64'h0, tag);
  endtask
  task automatic wr(input logic [15:0] ad, input logic [63:0] d, input string tag);
    step(0, 0, 0, 0, 1, 1, ad, 2'd3, d, tag);
  endtask

  function automatic logic [15:0] ix(input int i);
    return 16'(i << 6);
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    m_req = '0;
    for (int c = 0; c < NC; c++) m_mask[c] = '0;
    rst_n = 1'b0;
    src_raise_vld = 0; src_clr_vld = 0; src_raise_idx = 0; src_clr_idx = 0;
    reg_vld = 0; reg_wr = 0; reg_addr = 0; reg_size = 2'd3; reg_wdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check(cpu_irq == '0, "R1 irq", 256'(cpu_irq), 256'(0));
    check(evt_post == '0 && evt_clr == '0, "R1 events",
          256'(evt_post | evt_clr), 256'(0));
    check(reg_rdata == '0 && !reg_err, "R1 port", 256'(reg_rdata), 256'(0));
    rd(ix(2*NC), "R1 request reads zero");
    for (int c = 0; c < NC; c++) rd(ix(c), "R1 mask reads zero");

    // masks: three by normal index, one by alternate decode
    wr(ix(0), 64'hFFFF_FFFF_FFFF_FFFF, "R8 mask0 write");
    wr(ix(1), 64'hAAAA_AAAA_AAAA_AAAA, "R8 mask1 write");
    wr(ix(2), 64'h0F0F_0F0F_0F0F_0F0F, "R8 mask2 write");
    wr(16'h8000 | 16'(3 << 4), 64'h8000_0000_0000_0001, "R9 alt mask3 write");
    for (int c = 0; c < NC; c++) rd(ix(c), "R8 mask readback");
    rd(16'h8000 | 16'(2 << 4), "R9 alt mask2 read");
    rd(16'hC000 | 16'(1 << 4), "R9 bit15 over bit14");

    // raise sweep over every source
    for (int s = 0; s < NS; s++) begin
      raise_s(s, "R2 raise sweep");
      if (s % 8 == 7) rd(16'h4000 | 16'((s % NC) << 4), "R9 alt pending read");
    end
    raise_s(5, "R2 raise of already set source");
    rd(ix(2*NC), "R8 request read");
    for (int c = 0; c < NC; c++) rd(ix(NC + c), "R8 pending read");

    // mask updates
    wr(ix(1), 64'h5555_5555_5555_5555, "R6 mask1 flip");
    wr(ix(0), 64'hFFFF_FFFF_FFFF_FFFF, "R6 mask0 unchanged");
    wr(ix(2), 64'h0, "R6 mask2 to zero");
    wr(ix(2), 64'h00FF_0000_0000_FF00, "R6 mask2 partial");
    step(1, 9, 0, 0, 1, 1, ix(3), 2'd3, 64'h0000_0000_0000_0200,
         "R6 R2 raise with mask write");

    // clear sweep, each followed by a spurious clear of the same source
    for (int s = 0; s < NS; s++) begin
      clear_s(s, "R3 clear sweep");
      clear_s(s, "R4 spurious clear");
    end
    rd(ix(2*NC), "R4 request after sweep");

    // raise and clear of the same source together
    step(1, 9, 1, 9, 0, 0, 16'h0, 2'd3, 64'h0, "R5 both on idle source");
    step(1, 9, 1, 9, 0, 0, 16'h0, 2'd3, 64'h0, "R5 both on set source");
    step(1, 10, 1, 9, 0, 0, 16'h0, 2'd3, 64'h0, "R3 R2 different sources");
    rd(ix(2*NC), "R5 request read");

    // refused accesses
    step(0, 0, 0, 0, 1, 1, ix(0), 2'd2, 64'h1234, "R10 short write");
    step(0, 0, 0, 0, 1, 0, ix(1), 2'd0, 64'h0, "R10 short read");
    wr(16'h0008, 64'h1, "R10 misaligned write");
    rd(ix(2*NC + 1), "R10 undecoded read");
    wr(ix(NC), 64'h1, "R10 pending write");
    wr(ix(2*NC), 64'h1, "R10 request write");
    wr(16'h8000 | 16'(5 << 4), 64'h1, "R10 alt cpu out of range");
    wr(16'h4000, 64'h1, "R10 alt pending write");
    for (int c = 0; c < NC; c++) rd(ix(c), "R10 masks untouched");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule